// File: doc/BRIEF.md
# Two-Wire Bus Byte Shifter with Arbitration Monitor

This block is the data path of a master on a multi-master two-wire bus whose lines are open-drain. It holds one byte in an 8-bit shift register, presents the most significant bit first on the data line, and samples the real line level on every rising clock event. The sampled level is shifted in while the block transmits, so the register always ends a byte holding what was actually on the bus, not what the block meant to send.

While it acts as a master transmitter, the block compares each 1 it releases against the sampled line. If another master holds the line low, arbitration is lost. The block then stops driving for the rest of the byte but keeps asking for clock pulses until the byte is complete, so that it can continue as a receiver with correct data. While it acts as a master receiver, arbitration can only be lost in the acknowledge slot, when the block answers "not acknowledge" and another device pulls the line low. In that case the block withdraws its clock request at once.

Clock generation and the protocol state machine sit outside the block. They feed it rising and falling clock-event strobes, the sampled data line, a byte to load, a direction select and a start strobe. They read back the pull-low enable, the clock-continue request, a sticky arbitration-lost flag, a byte-done strobe and the register contents.

Top module: `twowire_byte_shifter`

## Requirements
- R1: A start strobe accepted while idle loads `data_o` with `load_byte_i` when `mode_i`=0 (transmit) or with 8'hFF when `mode_i`=1 (receive), and raises `clk_run_o` on the next cycle.
- R2: In transmit mode the bit presented is bit 7 of `data_o`. `sda_pull_o`=1 (pull low) exactly when that bit is 0. The first bit is set up by the start strobe and each later bit by a falling event.
- R3: On each of the 8 data rising events, `data_o` shifts left by one and the sampled `sda_i` enters bit 0. The first sampled bit ends in bit 7.
- R4: `byte_done_o` is high for exactly one cycle, the cycle after the eighth data rising event, and is low at all other times.
- R5: In transmit mode, a rising event that samples `sda_i`=0 while the block presents a 1 sets `arb_lost_o` on the next cycle. From then until the end of the byte, `sda_pull_o` stays 0.
- R6: After losing arbitration in transmit mode, `clk_run_o` stays high through the remaining data bits. It drops at the falling event after the eighth data bit, and no acknowledge slot follows.
- R7: In receive mode, `sda_pull_o` is 0 during the 8 data bits. In the acknowledge slot it is 1 when `nack_i` (latched at start) is 0, and 0 when `nack_i` is 1.
- R8: In receive mode with `nack_i`=1, if `sda_i`=0 is sampled at the acknowledge rising event, `arb_lost_o` is set and `clk_run_o` is low on the next cycle.
- R9: A transfer without loss ends after nine clock periods: `clk_run_o` is still high after the acknowledge rising event and drops at the following falling event.
- R10: `arb_lost_o` stays set until an `arb_clr_i` strobe clears it (a detection in the same cycle takes priority). It is detected at most once per byte, so after a mid-byte clear it is not set again within that byte.
- R11: A start strobe received while a transfer is in progress is ignored. The data, drive and direction of the current byte are unchanged.
- R12: After synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a byte transfer (SCL assumed low) |
| mode_i | input | 1 | 0 = master transmit, 1 = master receive |
| load_byte_i | input | 8 | Byte to send in transmit mode |
| nack_i | input | 1 | Receive mode: 1 answers not-acknowledge |
| scl_rise_i | input | 1 | One-cycle strobe on a clock-line rising event |
| scl_fall_i | input | 1 | One-cycle strobe on a clock-line falling event |
| sda_i | input | 1 | Synchronised data-line level |
| arb_clr_i | input | 1 | Clears the arbitration-lost flag |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| clk_run_o | output | 1 | Requests further clock pulses |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| byte_done_o | output | 1 | One-cycle strobe after the eighth data bit |
| data_o | output | 8 | Shift register contents |

## Verification
The bench drives an open-drain bus model in which a competing master can pull any bit low. It provokes loss on the first differing bit, on the final bit, and in the acknowledge slot. A design that dropped the clock too early after a transmit loss would leave `data_o` short of its last bits. A design that stopped the clock too late after a receive loss would keep `clk_run_o` high after the acknowledge rising event. The bench also clears the flag in the middle of a byte after a loss, then lets the competitor win more bits; a flag that re-armed within the byte would reappear. Finally, it injects a transmit start during a receive byte, which a design without a busy guard would take up by pulling the line low or reloading the register.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic {
    XFER_TX = 1'b0,
    XFER_RX = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/tws_seq.sv
module tws_seq #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          arb_hit_i,
  input  logic          lost_byte_i,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o,
  output logic          shift_en_o,
  output logic          clk_run_o,
  output logic          byte_done_o
);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);
  localparam logic [CW-1:0] ACK_IDX  = CW'(W);
  localparam logic [CW-1:0] END_IDX  = CW'(W + 1);

  logic          busy_q, run_q, done_q;
  logic [CW-1:0] cnt_q;

  assign shift_en_o  = busy_q && rise_i && (cnt_q < ACK_IDX);
  assign busy_o      = busy_q;
  assign cnt_o       = cnt_q;
  assign clk_run_o   = run_q;
  assign byte_done_o = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        run_q  <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (rise_i) begin
          if (cnt_q < ACK_IDX) begin
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == LAST_IDX) done_q <= 1'b1;
          end else if (cnt_q == ACK_IDX) begin
            cnt_q <= cnt_q + CW'(1);
            if (arb_hit_i) begin
              busy_q <= 1'b0;
              run_q  <= 1'b0;
            end
          end
        end else if (fall_i) begin
          if ((cnt_q == ACK_IDX && lost_byte_i) || cnt_q == END_IDX) begin
            busy_q <= 1'b0;
            run_q  <= 1'b0;
          end
        end
      end
    end
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    byte_done_o |=> !byte_done_o);
  a_r6_tx_keeps_clock: assert property (@(posedge clk) disable iff (rst)
    (busy_q && lost_byte_i && cnt_q < ACK_IDX) |-> run_q);
  a_r8_rx_stop_now: assert property (@(posedge clk) disable iff (rst)
    (busy_q && rise_i && cnt_q == ACK_IDX && arb_hit_i) |=> !clk_run_o);
endmodule

// File: rtl/tws_shift.sv
module tws_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_en_i,
  input  logic         sda_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= load_val_i;
    end else if (shift_en_i) begin
      sr_q <= {sr_q[W-2:0], sda_i};
    end
  end

  assign data_o = sr_q;

  a_r1_load_value: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (data_o == $past(load_val_i)));
endmodule

// File: rtl/tws_arb.sv
module tws_arb
  import tws_pkg::*;
#(
  parameter int W = 8,
  localparam int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  logic          mode_i,
  input  logic          load_msb_i,
  input  logic          nack_i,
  input  logic          busy_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          sda_i,
  input  logic          tx_bit_i,
  input  logic          clr_i,
  output logic          arb_hit_o,
  output logic          lost_byte_o,
  output logic          arb_lost_o,
  output logic          sda_pull_o
);
  localparam logic [CW-1:0] ACK_IDX = CW'(W);

  xfer_mode_e mode_q;
  logic       nack_q, lost_q, flag_q, pull_q;
  logic       in_data, in_ack, tx_hit, rx_hit;

  assign in_data   = cnt_i < ACK_IDX;
  assign in_ack    = cnt_i == ACK_IDX;
  assign tx_hit    = busy_i && rise_i && in_data && mode_q == XFER_TX
                     && !lost_q && tx_bit_i && !sda_i;
  assign rx_hit    = busy_i && rise_i && in_ack && mode_q == XFER_RX
                     && !lost_q && nack_q && !sda_i;
  assign arb_hit_o = tx_hit || rx_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= XFER_TX;
      nack_q <= 1'b0;
      lost_q <= 1'b0;
      flag_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      if (arb_hit_o)   flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;

      if (accept_i) begin
        mode_q <= xfer_mode_e'(mode_i);
        nack_q <= nack_i;
        lost_q <= 1'b0;
        pull_q <= (xfer_mode_e'(mode_i) == XFER_TX) && !load_msb_i;
      end else if (busy_i) begin
        if (arb_hit_o) begin
          lost_q <= 1'b1;
          pull_q <= 1'b0;
        end else if (fall_i) begin
          if (in_data)
            pull_q <= (mode_q == XFER_TX) && !lost_q && !tx_bit_i;
          else if (in_ack)
            pull_q <= (mode_q == XFER_RX) && !lost_q && !nack_q;
          else
            pull_q <= 1'b0;
        end
      end else begin
        pull_q <= 1'b0;
      end
    end
  end

  assign lost_byte_o = lost_q;
  assign arb_lost_o  = flag_q;
  assign sda_pull_o  = pull_q;

  a_r5_flag_follows_loss: assert property (@(posedge clk) disable iff (rst)
    arb_hit_o |=> arb_lost_o);
  a_r5_release_after_loss: assert property (@(posedge clk) disable iff (rst)
    (busy_i && lost_q) |-> !sda_pull_o);
  a_r7_rx_data_released: assert property (@(posedge clk) disable iff (rst)
    (busy_i && mode_q == XFER_RX && in_data) |-> !sda_pull_o);
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (arb_lost_o && !clr_i) |=> arb_lost_o);
endmodule

// File: rtl/twowire_byte_shifter.sv
module twowire_byte_shifter
  import tws_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] load_byte_i,
  input  logic         nack_i,
  input  logic         scl_rise_i,
  input  logic         scl_fall_i,
  input  logic         sda_i,
  input  logic         arb_clr_i,
  output logic         sda_pull_o,
  output logic         clk_run_o,
  output logic         arb_lost_o,
  output logic         byte_done_o,
  output logic [W-1:0] data_o
);
  localparam int CW = $clog2(W + 2);

  logic          busy, shift_en, accept, arb_hit, lost_byte;
  logic [CW-1:0] cnt;
  logic [W-1:0]  load_val;

  assign accept   = start_i && !busy;
  assign load_val = (xfer_mode_e'(mode_i) == XFER_RX) ? {W{1'b1}} : load_byte_i;

  tws_seq #(.W(W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rise_i      (scl_rise_i),
    .fall_i      (scl_fall_i),
    .arb_hit_i   (arb_hit),
    .lost_byte_i (lost_byte),
    .busy_o      (busy),
    .cnt_o       (cnt),
    .shift_en_o  (shift_en),
    .clk_run_o   (clk_run_o),
    .byte_done_o (byte_done_o)
  );

  tws_shift #(.W(W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .load_val_i (load_val),
    .shift_en_i (shift_en),
    .sda_i      (sda_i),
    .data_o     (data_o)
  );

  tws_arb #(.W(W)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .accept_i    (accept),
    .mode_i      (mode_i),
    .load_msb_i  (load_byte_i[W-1]),
    .nack_i      (nack_i),
    .busy_i      (busy),
    .rise_i      (scl_rise_i),
    .fall_i      (scl_fall_i),
    .cnt_i       (cnt),
    .sda_i       (sda_i),
    .tx_bit_i    (data_o[W-1]),
    .clr_i       (arb_clr_i),
    .arb_hit_o   (arb_hit),
    .lost_byte_o (lost_byte),
    .arb_lost_o  (arb_lost_o),
    .sda_pull_o  (sda_pull_o)
  );

  a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i && !scl_rise_i) |=> (data_o == $past(data_o)));
endmodule

// File: tb/test_twowire_byte_shifter.sv
module test_twowire_byte_shifter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_s = 0, mode_s = 0, nack_s = 0, rise_s = 0, fall_s = 0, clr_s = 0;
  logic [7:0] load_s = 8'h00;
  logic       other_low = 1'b0;
  logic       sda_bus;
  logic       sda_pull, clk_run, arb_lost, byte_done;
  logic [7:0] data;
  int         checks = 0, errors = 0;
  logic       exp_flag = 1'b0;
  bit         finished = 0;

  always #4 clk = ~clk;

  assign sda_bus = ~(sda_pull | other_low);

  twowire_byte_shifter i_twowire_byte_shifter (
    .clk(clk), .rst(rst), .start_i(start_s), .mode_i(mode_s), .load_byte_i(load_s),
    .nack_i(nack_s), .scl_rise_i(rise_s), .scl_fall_i(fall_s), .sda_i(sda_bus),
    .arb_clr_i(clr_s), .sda_pull_o(sda_pull), .clk_run_o(clk_run),
    .arb_lost_o(arb_lost), .byte_done_o(byte_done), .data_o(data)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic tick; @(negedge clk); endtask
  task automatic do_rise; rise_s = 1; @(negedge clk); rise_s = 0; endtask
  task automatic do_fall; fall_s = 1; @(negedge clk); fall_s = 0; endtask

  task automatic clear_flag;
    clr_s = 1; @(negedge clk); clr_s = 0;
    exp_flag = 0;
    chk(arb_lost == 1'b0, "R10", "flag after clear", arb_lost, 0);
    tick;
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Transmit one byte; opp bit = 1 means a competing master pulls that bit low.
  task automatic tx_byte(input logic [7:0] b, input logic [7:0] opp, input int clr_after);
    logic       lost = 0;
    logic       drv, bus;
    logic [7:0] exp_data;
    mode_s = 0; load_s = b; start_s = 1; tick; start_s = 0;
    chk(data == b, "R1", "tx load data", data, b);
    chk(clk_run == 1'b1, "R1", "clk_run after start", clk_run, 1);
    exp_data = b;
    for (int i = 7; i >= 0; i--) begin
      drv = !lost && !b[i];
      chk(sda_pull == drv, lost ? "R5" : "R2", "tx drive", sda_pull, drv);
      other_low = opp[i];
      bus = !(drv | opp[i]);
      if (!lost && b[i] && !bus) begin lost = 1; exp_flag = 1; end
      exp_data = {exp_data[6:0], bus};
      do_rise;
      chk(arb_lost == exp_flag, "R5", "tx arb flag", arb_lost, exp_flag);
      chk(byte_done == (i == 0), "R4", "byte_done", byte_done, (i == 0));
      chk(clk_run == 1'b1, "R6", "clock held in byte", clk_run, 1);
      tick; do_fall; other_low = 0; tick;
      if (clr_after == i) clear_flag();
    end
    chk(data == exp_data, "R3", "tx shifted-in byte", data, exp_data);
    chk(byte_done == 1'b0, "R4", "byte_done low later", byte_done, 0);
    if (lost) begin
      chk(clk_run == 1'b0, "R6", "clock stops at byte end", clk_run, 0);
      chk(arb_lost == exp_flag, "R10", "flag at byte end", arb_lost, exp_flag);
    end else begin
      chk(sda_pull == 1'b0, "R2", "tx ack slot released", sda_pull, 0);
      other_low = 1;
      do_rise;
      chk(clk_run == 1'b1, "R9", "clock after ack rise", clk_run, 1);
      other_low = 0; tick; do_fall;
      chk(clk_run == 1'b0, "R9", "clock after ack fall", clk_run, 0);
    end
    tick;
  endtask

  // Receive one byte od; inject_at >= 0 pulses a transmit start before that bit.
  task automatic rx_byte(input logic [7:0] od, input logic nack, input logic ack_low,
                         input int inject_at);
    logic       lost, drv;
    logic [7:0] exp_data = 8'hFF;
    mode_s = 1; nack_s = nack; load_s = 8'h00; start_s = 1; tick; start_s = 0;
    chk(data == 8'hFF, "R1", "rx load value", data, 8'hFF);
    for (int i = 7; i >= 0; i--) begin
      if (inject_at == i) begin
        mode_s = 0; load_s = 8'h00; start_s = 1; tick; start_s = 0; tick;
        chk(data == exp_data, "R11", "data kept on busy start", data, exp_data);
        chk(sda_pull == 1'b0, "R11", "drive kept on busy start", sda_pull, 0);
      end
      chk(sda_pull == 1'b0, "R7", "rx data released", sda_pull, 0);
      other_low = !od[i];
      exp_data = {exp_data[6:0], od[i]};
      do_rise;
      chk(byte_done == (i == 0), "R4", "rx byte_done", byte_done, (i == 0));
      tick; do_fall; other_low = 0; tick;
    end
    chk(data == od, "R3", "rx byte", data, od);
    drv = !nack;
    chk(sda_pull == drv, "R7", "rx ack drive", sda_pull, drv);
    other_low = ack_low;
    lost = nack && ack_low;
    if (lost) exp_flag = 1;
    do_rise;
    chk(arb_lost == exp_flag, "R8", "rx ack flag", arb_lost, exp_flag);
    chk(clk_run == !lost, lost ? "R8" : "R9", "clock after ack rise", clk_run, !lost);
    other_low = 0; tick; do_fall;
    chk(clk_run == 1'b0, "R9", "clock after ack fall", clk_run, 0);
    chk(data == od, "R3", "ack not shifted", data, od);
    tick;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run hung actual=0 expected=1");
    finish_up();
  end

  initial begin
    repeat (3) tick;
    rst = 0; tick;
    chk(sda_pull == 0 && clk_run == 0 && arb_lost == 0 && byte_done == 0,
        "R12", "control outputs after reset", {sda_pull, clk_run, arb_lost, byte_done}, 0);
    chk(data == 8'h00, "R12", "data after reset", data, 0);
    tx_byte(8'hA5, 8'h00, -1);
    tx_byte(8'h3C, 8'h00, -1);
    tx_byte(8'h80, 8'h7F, -1);   // competitor agrees on all zero bits: no loss
    tx_byte(8'hF0, 8'h40, -1);   // loss on bit 6
    clear_flag();
    tx_byte(8'hFF, 8'h01, -1);   // loss on last bit
    clear_flag();
    tx_byte(8'hFF, 8'h25, 5);    // loss at bit 5, cleared mid-byte, no re-set
    rx_byte(8'h5A, 1'b0, 1'b0, -1);
    rx_byte(8'hC3, 1'b1, 1'b0, -1);
    rx_byte(8'h96, 1'b1, 1'b1, -1); // loss in acknowledge slot
    clear_flag();
    rx_byte(8'h69, 1'b0, 1'b1, 3);  // start ignored while busy
    finish_up();
  end
endmodule